// File: doc/BRIEF.md
# Shared multi-VC flit buffer

This block is the input-side storage of a router port. Flits for several virtual channels arrive on one write port, each tagged with its channel number, and all of them land in one small physical memory split into equal, power-of-two-sized regions, one region per channel. Each region acts as a FIFO. Its head pointer, tail pointer and occupancy count live in a small register set of their own. The memory is made of plain registers and has an asynchronous read, so it maps onto LUT-based distributed RAM and needs no block RAM.

The read side names a channel and receives that channel's oldest flit in the same cycle. The flit is dequeued at the next clock edge. The live occupancy of every channel is driven on output wires, so the upstream router can see how much space is free downstream without any credit return. A write that finds its channel full is discarded, and a sticky error flag records the event.

Top module: `vc_flit_store`

## Requirements
- R1: After reset every channel's occupancy reads 0, `rd_valid` is 0 and `overflow_err` is 0.
- R2: A write (`wr_valid`=1) to channel v whose occupancy is below DEPTH is stored and raises v's occupancy by one at the next edge. Channel v's count sits in `occupancy[v*CNT_W +: CNT_W]`, where CNT_W = clog2(DEPTH+1).
- R3: Each channel returns its flits in the order they were written, even when writes and reads to different channels interleave.
- R4: A write to a channel whose occupancy is DEPTH at the start of the cycle is dropped: occupancy and stored flits are unchanged, even if the same channel is read in that cycle. `overflow_err` becomes 1 at the next edge and stays 1 until reset.
- R5: With `rd_req`=1 to a non-empty channel, `rd_valid` is 1 and `rd_flit` holds that channel's oldest flit in the same cycle. The flit is removed and the occupancy drops by one at the next edge.
- R6: With `rd_req`=1 to an empty channel, `rd_valid` is 0, `rd_flit` is 0 and no pointer or count changes. A write to that channel in the same cycle is not passed through to the read side. Whenever `rd_valid` is 0, `rd_flit` is 0.
- R7: A read and an accepted write to the same channel in one cycle leave its occupancy unchanged, and both take effect.
- R8: A channel targeted by neither the write nor the read in a cycle keeps its occupancy.
- R9: Pointers wrap inside their region, so a channel can be filled, drained and refilled any number of times with the order kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write request |
| wr_vc | input | VC_W | Channel of the incoming flit |
| wr_flit | input | FLIT_W | Incoming flit |
| rd_req | input | 1 | Dequeue request |
| rd_vc | input | VC_W | Channel to dequeue from |
| rd_valid | output | 1 | Requested channel had a flit |
| rd_flit | output | FLIT_W | Oldest flit of the requested channel, 0 when not valid |
| occupancy | output | NUM_VC*CNT_W | Live per-channel flit counts |
| overflow_err | output | 1 | Sticky flag: a write was dropped |

## Verification
The bench builds the block with four channels, eight entries per channel and 16-bit flits. This gives a 32-word array where every region boundary is reachable in a few dozen cycles. With eight entries, a channel can be driven to full, overflowed while being read in the same cycle, and wrapped more than once within a short directed test. Four channels are enough to check isolation between regions that sit next to each other in the address space, including the last region, whose address uses the top bits of the channel index.

// File: rtl/vcbuf_pkg.sv
package vcbuf_pkg;
    localparam int unsigned DEF_NUM_VC = 4;
    localparam int unsigned DEF_DEPTH  = 8;
    localparam int unsigned DEF_FLIT_W = 32;
endpackage

// File: rtl/vcbuf_ram.sv
module vcbuf_ram #(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned WORDS = 1 << ADDR_W;

    // Register array without reset and with an asynchronous read: fits LUT RAM
    logic [DATA_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/vcbuf_lane.sv
module vcbuf_lane #(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    output logic [PTR_W-1:0] head,
    output logic [PTR_W-1:0] tail,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [PTR_W-1:0] head;
        logic [PTR_W-1:0] tail;
        logic [CNT_W-1:0] cnt;
    } lane_t;

    lane_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push) st_d.tail = st_q.tail + PTR_W'(1);
        if (pop)  st_d.head = st_q.head + PTR_W'(1);
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + CNT_W'(1);
            2'b01:   st_d.cnt = st_q.cnt - CNT_W'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head  = st_q.head;
    assign tail  = st_q.tail;
    assign count = st_q.cnt;
endmodule

// File: rtl/vc_flit_store.sv
module vc_flit_store #(
    parameter int unsigned NUM_VC = vcbuf_pkg::DEF_NUM_VC,
    parameter int unsigned DEPTH  = vcbuf_pkg::DEF_DEPTH,
    parameter int unsigned FLIT_W = vcbuf_pkg::DEF_FLIT_W,
    localparam int unsigned VC_W   = $clog2(NUM_VC),
    localparam int unsigned PTR_W  = $clog2(DEPTH),
    localparam int unsigned CNT_W  = $clog2(DEPTH + 1),
    localparam int unsigned ADDR_W = VC_W + PTR_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_valid,
    input  logic [VC_W-1:0]         wr_vc,
    input  logic [FLIT_W-1:0]       wr_flit,
    input  logic                    rd_req,
    input  logic [VC_W-1:0]         rd_vc,
    output logic                    rd_valid,
    output logic [FLIT_W-1:0]       rd_flit,
    output logic [NUM_VC*CNT_W-1:0] occupancy,
    output logic                    overflow_err
);
    logic [PTR_W-1:0] head_w [NUM_VC];
    logic [PTR_W-1:0] tail_w [NUM_VC];
    logic [CNT_W-1:0] cnt_w  [NUM_VC];
    logic [NUM_VC-1:0] push_v, pop_v;

    logic wr_full, wr_ok, rd_ok;
    logic [FLIT_W-1:0] ram_q;
    logic err_d, err_q;

    // Fullness and emptiness are taken from the counts at the start of the cycle
    assign wr_full = (cnt_w[wr_vc] == CNT_W'(DEPTH));
    assign wr_ok   = wr_valid && !wr_full;
    assign rd_ok   = rd_req && (cnt_w[rd_vc] != '0);

    for (genvar v = 0; v < NUM_VC; v++) begin : g_lane
        assign push_v[v] = wr_ok && (wr_vc == VC_W'(v));
        assign pop_v[v]  = rd_ok && (rd_vc == VC_W'(v));

        vcbuf_lane #(.DEPTH(DEPTH)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (push_v[v]),
            .pop   (pop_v[v]),
            .head  (head_w[v]),
            .tail  (tail_w[v]),
            .count (cnt_w[v])
        );

        assign occupancy[v*CNT_W +: CNT_W] = cnt_w[v];
    end

    // Region address: channel index on top, local pointer below
    vcbuf_ram #(.ADDR_W(ADDR_W), .DATA_W(FLIT_W)) u_ram (
        .clk   (clk),
        .we    (wr_ok),
        .waddr ({wr_vc, tail_w[wr_vc]}),
        .wdata (wr_flit),
        .raddr ({rd_vc, head_w[rd_vc]}),
        .rdata (ram_q)
    );

    always_comb begin
        err_d = err_q;
        if (wr_valid && wr_full) err_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= err_d;
    end

    assign rd_valid     = rd_ok;
    assign rd_flit      = rd_ok ? ram_q : '0;
    assign overflow_err = err_q;
endmodule

// File: rtl/vcbuf_checks.sv
module vcbuf_checks #(
    parameter int unsigned NUM_VC = 4,
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned FLIT_W = 32,
    localparam int unsigned VC_W  = $clog2(NUM_VC),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    wr_valid,
    input logic [VC_W-1:0]         wr_vc,
    input logic                    rd_req,
    input logic [VC_W-1:0]         rd_vc,
    input logic                    rd_valid,
    input logic [FLIT_W-1:0]       rd_flit,
    input logic [NUM_VC*CNT_W-1:0] occupancy,
    input logic                    overflow_err
);
    logic [CNT_W-1:0] occ_a [NUM_VC];
    for (genvar v = 0; v < NUM_VC; v++) begin : g_occ
        assign occ_a[v] = occupancy[v*CNT_W +: CNT_W];

        // R2: a count never exceeds the region size
        a_r2_bounded: assert property (@(posedge clk) disable iff (!rst_n)
            occ_a[v] <= CNT_W'(DEPTH));

        // R8: an untouched channel keeps its count
        a_r8_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
            (!(wr_valid && wr_vc == VC_W'(v)) && !(rd_req && rd_vc == VC_W'(v)))
            |=> $stable(occ_a[v]));
    end

    // R4: dropped write raises the flag, and the flag holds
    a_r4_overflow_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && occ_a[wr_vc] == CNT_W'(DEPTH)) |=> overflow_err);

    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_err |=> overflow_err);

    // R6: reading an empty channel yields nothing
    a_r6_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && occ_a[rd_vc] == '0) |-> !rd_valid);

    a_r6_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_flit == '0));

    // R5: a valid read implies a request
    a_r5_valid_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> rd_req);
endmodule

bind vc_flit_store vcbuf_checks #(.NUM_VC(NUM_VC), .DEPTH(DEPTH), .FLIT_W(FLIT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_valid     (wr_valid),
    .wr_vc        (wr_vc),
    .rd_req       (rd_req),
    .rd_vc        (rd_vc),
    .rd_valid     (rd_valid),
    .rd_flit      (rd_flit),
    .occupancy    (occupancy),
    .overflow_err (overflow_err)
);

// File: tb/vc_flit_store_test.sv
`timescale 1ns/1ps
module vc_flit_store_test;
    localparam int unsigned NUM_VC = 4;
    localparam int unsigned DEPTH  = 8;
    localparam int unsigned FW     = 16;
    localparam int unsigned VC_W   = $clog2(NUM_VC);
    localparam int unsigned CNT_W  = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_valid = 1'b0;
    logic [VC_W-1:0] wr_vc = '0;
    logic [FW-1:0] wr_flit = '0;
    logic rd_req = 1'b0;
    logic [VC_W-1:0] rd_vc = '0;
    logic rd_valid;
    logic [FW-1:0] rd_flit;
    logic [NUM_VC*CNT_W-1:0] occupancy;
    logic overflow_err;

    int n_run = 0;
    int n_fail = 0;
    logic [FW-1:0] mq [NUM_VC][$];
    logic m_err = 1'b0;
    logic [FW-1:0] seq = 16'h1000;

    always #4 clk = ~clk;  // 125 MHz

    vc_flit_store #(.NUM_VC(NUM_VC), .DEPTH(DEPTH), .FLIT_W(FW)) uut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_vc(wr_vc),
        .wr_flit(wr_flit), .rd_req(rd_req), .rd_vc(rd_vc),
        .rd_valid(rd_valid), .rd_flit(rd_flit), .occupancy(occupancy),
        .overflow_err(overflow_err)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic check_state(input string tag);
        for (int v = 0; v < NUM_VC; v++)
            check(tag, 32'(occupancy[v*CNT_W +: CNT_W]), 32'(mq[v].size()), $sformatf("occupancy vc%0d", v));
        check(tag, 32'(overflow_err), 32'(m_err), "overflow_err");
    endtask

    // Called at a negedge; returns at the following negedge
    task automatic step(input logic wv, input int wvc, input logic rr, input int rvc, input string tag);
        logic exp_v;
        logic [FW-1:0] exp_d;
        logic pre_full;
        logic [FW-1:0] d;
        d = seq;
        seq = seq + 16'h0013;
        wr_valid = wv; wr_vc = VC_W'(wvc); wr_flit = d;
        rd_req = rr; rd_vc = VC_W'(rvc);
        #1;
        exp_v = rr && (mq[rvc].size() != 0);
        exp_d = exp_v ? mq[rvc][0] : '0;
        check(tag, 32'(rd_valid), 32'(exp_v), "rd_valid");
        check(tag, 32'(rd_flit), 32'(exp_d), "rd_flit");
        @(posedge clk);
        pre_full = (wv && mq[wvc].size() >= DEPTH);
        if (exp_v) void'(mq[rvc].pop_front());
        if (wv) begin
            if (!pre_full) mq[wvc].push_back(d);
            else m_err = 1'b1;
        end
        @(negedge clk);
        wr_valid = 1'b0; rd_req = 1'b0;
        check_state(tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wr_valid = 1'b0; rd_req = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int v = 0; v < NUM_VC; v++) mq[v].delete();
        m_err = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        check_state("R1");
        #1;
        check("R1", 32'(rd_valid), 32'd0, "rd_valid after reset");
    endtask

    task automatic t_fill_drain();
        for (int i = 0; i < 5; i++) step(1'b1, 0, 1'b0, 0, "R2");
        for (int i = 0; i < 5; i++) step(1'b0, 0, 1'b1, 0, "R5");
    endtask

    task automatic t_interleave();
        for (int i = 0; i < 12; i++) step(1'b1, i % NUM_VC, 1'b0, 0, "R3");
        for (int i = 0; i < 12; i++) step(1'b1, (i * 3) % NUM_VC, 1'b1, (i + 1) % NUM_VC, "R8");
        for (int v = 0; v < NUM_VC; v++)
            for (int i = 0; i < DEPTH; i++) step(1'b0, 0, 1'b1, v, "R3");
    endtask

    task automatic t_empty_read();
        step(1'b0, 0, 1'b1, 2, "R6");
        step(1'b1, 2, 1'b1, 2, "R6");   // same-cycle write must not bypass
        step(1'b0, 0, 1'b1, 2, "R6");
        step(1'b0, 0, 1'b1, 2, "R6");
    endtask

    task automatic t_same_vc();
        for (int i = 0; i < 3; i++) step(1'b1, 1, 1'b0, 0, "R7");
        for (int i = 0; i < 6; i++) step(1'b1, 1, 1'b1, 1, "R7");
        for (int i = 0; i < 3; i++) step(1'b0, 0, 1'b1, 1, "R7");
    endtask

    task automatic t_overflow();
        for (int i = 0; i < DEPTH; i++) step(1'b1, 3, 1'b0, 0, "R4");
        step(1'b1, 3, 1'b0, 0, "R4");   // full: dropped, flag set
        step(1'b1, 3, 1'b1, 3, "R4");   // full at cycle start even with read
        step(1'b0, 0, 1'b0, 0, "R4");   // flag stays
        for (int i = 0; i < DEPTH; i++) step(1'b0, 0, 1'b1, 3, "R4");
        do_reset();
        check_state("R4");
    endtask

    task automatic t_wrap();
        for (int r = 0; r < 3; r++) begin
            for (int i = 0; i < DEPTH; i++) step(1'b1, 0, 1'b0, 0, "R9");
            for (int i = 0; i < 5; i++) step(1'b0, 0, 1'b1, 0, "R9");
            for (int i = 0; i < 5; i++) step(1'b1, 0, 1'b0, 0, "R9");
            for (int i = 0; i < DEPTH; i++) step(1'b0, 0, 1'b1, 0, "R9");
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_fill_drain();
        t_interleave();
        t_empty_read();
        t_same_vc();
        t_overflow();
        t_wrap();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule